// File: doc/BRIEF.md
# Parallel SAR Converter Host Controller

This block runs on the host side of a successive-approximation converter that has a 13-bit parallel bus. It issues active-low conversion-start pulses at a rate set by a runtime period value. It then waits for the converter's conversion-active flag to fall and rise again, which marks the end of a conversion. After that it reads the result with a select strobe and a read strobe, and presents the 12-bit sample and its overrange bit on a one-cycle valid output.

The host may also ask for the converter's offset register to be loaded. The controller checks that the signed request is in range and formats it into a 13-bit word. It drives that word onto the bus only while its write strobe is low, and only between conversions. After each read or write, a quiet window of bus inactivity must pass before the next start edge is allowed.

The controller also flags two faults. A period that is too short for a full start, conversion, read and quiet cycle raises an overrun. A converter that never finishes a conversion raises a timeout.

Top module: `adc_par_host`

## Requirements
- R1: While reset is asserted and just after its release, `cstart_no`, `sel_no`, `rstb_no` and `wstb_no` are high, and `dbus_oe_o`, `smp_valid_o`, `ofs_done_o`, `ofs_err_o`, `overrun_o` and `conv_tmo_o` are low.
- R2: When the period counter expires and no sample is in flight, the controller drives `cstart_no` low for exactly CNV_LOW clock cycles.
- R3: The read and write strobes never go low while `conv_active_ni` is low. A read begins only after `conv_active_ni` has been seen low and then high again after the start edge.
- R4: A read holds `sel_no` and `rstb_no` low together for RD_W cycles. The bus word is captured on the last of those cycles: bit 12 goes to `smp_ovr_o` and bits 11:0 go to `smp_data_o`. `smp_valid_o` pulses for one cycle, in the first cycle after the read strobe returns high.
- R5: After any read or write strobe ends, at least QUIET cycles with all strobes high pass before the next falling edge of `cstart_no`. A start that falls due earlier is delayed, not dropped.
- R6: An offset request in the range -327 to +327 is sent as the word {3'b000, value[9:0] in two's complement}. The write holds `sel_no` and `wstb_no` low for WR_W cycles, and `ofs_done_o` pulses at the end of the write.
- R7: With OFF_CLAMP at 0, a request outside -327 to +327 produces a one-cycle `ofs_err_o` pulse in the cycle after the request, and no write strobe follows.
- R8: A write requested during a conversion is performed after that conversion's read and before the next start edge. If several requests arrive before the write, only the last one is written.
- R9: A period expiry that occurs while a start is pending or a conversion or read is under way raises a one-cycle `overrun_o` pulse and is dropped.
- R10: If the conversion has not ended BUSY_TMO cycles after the start edge, `conv_tmo_o` pulses exactly BUSY_TMO cycles after the start edge, no read is made, and the controller returns to idle.
- R11: At most one of `cstart_no`, `rstb_no` and `wstb_no` is low in any cycle, and `dbus_oe_o` is high only while `wstb_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_en_i | input | 1 | Enables the sample-period counter |
| period_i | input | PER_W | Sample period in clock cycles |
| cstart_no | output | 1 | Conversion start, active low; the falling edge starts a conversion |
| conv_active_ni | input | 1 | Converter flag, low while a conversion is running |
| sel_no | output | 1 | Converter select, active low |
| rstb_no | output | 1 | Read strobe, active low |
| wstb_no | output | 1 | Write strobe, active low |
| dbus_i | input | 13 | Bus value driven by the converter |
| dbus_o | output | 13 | Bus value driven by the controller |
| dbus_oe_o | output | 1 | High when the controller drives the bus |
| smp_valid_o | output | 1 | One-cycle pulse when a sample is ready |
| smp_data_o | output | 12 | Conversion result |
| smp_ovr_o | output | 1 | Overrange flag of the sample |
| ofs_req_i | input | 1 | One-cycle request to load the offset register |
| ofs_val_i | input | OFF_IN_W | Signed offset value of the request |
| ofs_done_o | output | 1 | Pulse when an offset write completes |
| ofs_err_o | output | 1 | Pulse when an offset request is rejected |
| overrun_o | output | 1 | Pulse when a period expiry is dropped |
| conv_tmo_o | output | 1 | Pulse when a conversion does not end in time |

## Verification
A sequencer stuck in the wrong state shows at once as a strobe that is too long or missing. It can also show as two strobes low together, or as a read strobe while the converter is still active. The bench sees each of these within one sample period. A wrong quiet counter or wrong pending flags show as a start edge that comes too soon after a write, or as a write that lands in the wrong place relative to the read and the next start. A miscounted timeout moves the timeout pulse away from the expected cycle offset from the start edge.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int unsigned WORD_W = 13;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned OFS_BITS = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_CONV,
    ST_READ,
    ST_WRITE
  } host_st_e;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_no = sh_q[1];
endmodule

// File: rtl/adc_rate_gen.sv
module adc_rate_gen #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W:0]   nxt;

  always_comb begin
    nxt    = {1'b0, cnt_q} + 1'b1;
    tick_o = en_i && (nxt >= {1'b0, period_i});
    if (!en_i || tick_o) cnt_d = '0;
    else                 cnt_d = nxt[PER_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_quiet_tmr.sv
module adc_quiet_tmr #(
  parameter int unsigned QUIET = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic ok_o
);
  localparam int unsigned QW = $clog2(QUIET + 2);
  logic [QW-1:0] qc_q, qc_d;

  always_comb begin
    qc_d = qc_q;
    if (load_i)          qc_d = QW'(QUIET);
    else if (qc_q != '0) qc_d = qc_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qc_q <= '0;
    else         qc_q <= qc_d;
  end

  assign ok_o = (qc_q == '0);
endmodule

// File: rtl/adc_ofs_fmt.sv
module adc_ofs_fmt
  import adc_host_pkg::*;
#(
  parameter int unsigned OFF_IN_W  = 11,
  parameter int unsigned OFF_LIM   = 327,
  parameter bit          OFF_CLAMP = 1'b0
) (
  input  logic signed [OFF_IN_W-1:0] val_i,
  output logic                       ok_o,
  output logic [WORD_W-1:0]          word_o
);
  localparam logic signed [OFF_IN_W-1:0] LIM_P = OFF_IN_W'(OFF_LIM);
  localparam logic signed [OFF_IN_W-1:0] LIM_N = -LIM_P;
  localparam logic [WORD_W-1:0] MASK = WORD_W'((1 << OFS_BITS) - 1);

  logic signed [OFF_IN_W-1:0] sat;
  logic                       in_rng;

  assign in_rng = (val_i <= LIM_P) && (val_i >= LIM_N);

  generate
    if (OFF_CLAMP) begin : g_clamp
      always_comb begin
        if (val_i > LIM_P)      sat = LIM_P;
        else if (val_i < LIM_N) sat = LIM_N;
        else                    sat = val_i;
      end
      assign ok_o = 1'b1;
    end else begin : g_reject
      assign sat  = val_i;
      assign ok_o = in_rng;
    end
  endgenerate

  assign word_o = WORD_W'(sat) & MASK;
endmodule

// File: rtl/adc_par_host.sv
module adc_par_host
  import adc_host_pkg::*;
#(
  parameter int unsigned PER_W     = 16,
  parameter int unsigned CNV_LOW   = 2,
  parameter int unsigned RD_W      = 3,
  parameter int unsigned WR_W      = 3,
  parameter int unsigned QUIET     = 4,
  parameter int unsigned BUSY_TMO  = 40,
  parameter int unsigned OFF_IN_W  = 11,
  parameter int unsigned OFF_LIM   = 327,
  parameter bit          OFF_CLAMP = 1'b0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       run_en_i,
  input  logic [PER_W-1:0]           period_i,
  output logic                       cstart_no,
  input  logic                       conv_active_ni,
  output logic                       sel_no,
  output logic                       rstb_no,
  output logic                       wstb_no,
  input  logic [12:0]                dbus_i,
  output logic [12:0]                dbus_o,
  output logic                       dbus_oe_o,
  output logic                       smp_valid_o,
  output logic [11:0]                smp_data_o,
  output logic                       smp_ovr_o,
  input  logic                       ofs_req_i,
  input  logic signed [OFF_IN_W-1:0] ofs_val_i,
  output logic                       ofs_done_o,
  output logic                       ofs_err_o,
  output logic                       overrun_o,
  output logic                       conv_tmo_o
);
  localparam int unsigned SMAX = (CNV_LOW > RD_W) ? ((CNV_LOW > WR_W) ? CNV_LOW : WR_W)
                                                  : ((RD_W > WR_W) ? RD_W : WR_W);
  localparam int unsigned SCW = $clog2(SMAX + 1);
  localparam int unsigned TMW = $clog2(BUSY_TMO + 1);

  logic rst_n, tick, quiet_ok, fmt_ok, qload;
  logic [WORD_W-1:0] fmt_word;

  adc_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  adc_rate_gen #(.PER_W(PER_W)) u_rate (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(run_en_i), .period_i(period_i), .tick_o(tick)
  );

  adc_quiet_tmr #(.QUIET(QUIET)) u_quiet (
    .clk_i(clk_i), .rst_ni(rst_n), .load_i(qload), .ok_o(quiet_ok)
  );

  adc_ofs_fmt #(.OFF_IN_W(OFF_IN_W), .OFF_LIM(OFF_LIM), .OFF_CLAMP(OFF_CLAMP)) u_fmt (
    .val_i(ofs_val_i), .ok_o(fmt_ok), .word_o(fmt_word)
  );

  host_st_e          st_q, st_d;
  logic [SCW-1:0]    cnt_q, cnt_d;
  logic [TMW-1:0]    tcnt_q, tcnt_d;
  logic              seen_q, seen_d;
  logic              spend_q, spend_d;
  logic              wpend_q, wpend_d;
  logic [WORD_W-1:0] wword_q, wword_d;
  logic [WORD_W-1:0] bus_q, bus_d;
  logic [WORD_W-1:0] cap_q, cap_d;
  logic              vld_q, vld_d, done_q, done_d, err_q, err_d, ovr_q, ovr_d, tmo_q, tmo_d;
  logic              inflight, req_ok, cap_en, wword_en, bus_en;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    tcnt_d   = tcnt_q;
    seen_d   = seen_q;
    spend_d  = spend_q;
    wpend_d  = wpend_q;
    wword_d  = wword_q;
    bus_d    = bus_q;
    cap_d    = cap_q;
    vld_d    = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    ovr_d    = 1'b0;
    tmo_d    = 1'b0;
    qload    = 1'b0;
    cap_en   = 1'b0;
    bus_en   = 1'b0;
    req_ok   = ofs_req_i && fmt_ok;
    wword_en = req_ok;
    inflight = spend_q || (st_q inside {ST_START, ST_CONV, ST_READ});

    // R9: a period expiry while a sample is in flight is dropped and flagged
    if (tick) begin
      if (inflight) ovr_d   = 1'b1;
      else          spend_d = 1'b1;
    end

    if (req_ok) begin
      wpend_d = 1'b1;
      wword_d = fmt_word;
    end else if (ofs_req_i) begin
      err_d = 1'b1;
    end

    case (st_q)
      ST_IDLE: begin
        // R8: a pending offset write goes ahead of the next start
        if (wpend_q) begin
          st_d   = ST_WRITE;
          cnt_d  = SCW'(WR_W - 1);
          bus_d  = wword_q;
          bus_en = 1'b1;
          if (!req_ok) wpend_d = 1'b0;
        end else if (spend_q && quiet_ok) begin
          st_d    = ST_START;
          cnt_d   = SCW'(CNV_LOW - 1);
          tcnt_d  = '0;
          seen_d  = 1'b0;
          spend_d = 1'b0;
        end
      end
      ST_START: begin
        tcnt_d = tcnt_q + 1'b1;
        if (!conv_active_ni) seen_d = 1'b1;
        if (cnt_q == '0) st_d = ST_CONV;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_CONV: begin
        tcnt_d = tcnt_q + 1'b1;
        if (!conv_active_ni) seen_d = 1'b1;
        if (seen_q && conv_active_ni) begin
          st_d  = ST_READ;
          cnt_d = SCW'(RD_W - 1);
        end else if (tcnt_q >= TMW'(BUSY_TMO - 1)) begin
          st_d  = ST_IDLE;
          tmo_d = 1'b1;
        end
      end
      ST_READ: begin
        if (cnt_q == '0) begin
          cap_d  = dbus_i;
          cap_en = 1'b1;
          vld_d  = 1'b1;
          qload  = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WRITE: begin
        if (cnt_q == '0) begin
          done_d = 1'b1;
          qload  = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      tcnt_q  <= '0;
      seen_q  <= 1'b0;
      spend_q <= 1'b0;
      wpend_q <= 1'b0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ovr_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      tcnt_q  <= tcnt_d;
      seen_q  <= seen_d;
      spend_q <= spend_d;
      wpend_q <= wpend_d;
      vld_q   <= vld_d;
      done_q  <= done_d;
      err_q   <= err_d;
      ovr_q   <= ovr_d;
      tmo_q   <= tmo_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (cap_en)   cap_q   <= cap_d;
    if (wword_en) wword_q <= wword_d;
    if (bus_en)   bus_q   <= bus_d;
  end

  assign cstart_no   = (st_q != ST_START);
  assign rstb_no     = (st_q != ST_READ);
  assign wstb_no     = (st_q != ST_WRITE);
  assign sel_no      = !((st_q == ST_READ) || (st_q == ST_WRITE));
  assign dbus_oe_o   = (st_q == ST_WRITE);
  assign dbus_o      = bus_q;
  assign smp_valid_o = vld_q;
  assign smp_data_o  = cap_q[DATA_W-1:0];
  assign smp_ovr_o   = cap_q[WORD_W-1];
  assign ofs_done_o  = done_q;
  assign ofs_err_o   = err_q;
  assign overrun_o   = ovr_q;
  assign conv_tmo_o  = tmo_q;

  a_r3_no_strobe_busy: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!rstb_no || !wstb_no) |-> conv_active_ni);
  a_r11_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({!cstart_no, !rstb_no, !wstb_no}));
  a_r4_sel_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!rstb_no || !wstb_no) |-> !sel_no);
  a_r4_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_n)
    smp_valid_o |-> $past(!rstb_no));
  a_r5_quiet_gate: assert property (@(posedge clk_i) disable iff (!rst_n)
    !quiet_ok |=> !$fell(cstart_no));
  a_r7_err_from_req: assert property (@(posedge clk_i) disable iff (!rst_n)
    ofs_err_o |-> $past(ofs_req_i));
  a_r6_word_top_clear: assert property (@(posedge clk_i) disable iff (!rst_n)
    dbus_oe_o |-> (dbus_o[12:10] == 3'b000));
  a_r10_tmo_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    conv_tmo_o |-> (cstart_no && rstb_no && $past(!cstart_no || rstb_no)));
endmodule

// File: tb/sim_adc_par_host.sv
`timescale 1ns/1ps
module sim_adc_par_host;
  localparam int CNV_LOW = 2, RD_W = 3, WR_W = 3, QUIET = 4, BUSY_TMO = 40;
  localparam int CONV_CYC = 10, WDOG = 100000, NV = 10;
  localparam int VEC_VAL [NV] = '{-327, -128, 64, 327, 0, -1, 328, -328, 1023, -1024};
  localparam bit VEC_ERR [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1};
  localparam int VEC_WRD [NV] = '{'h2B9, 'h380, 'h040, 'h147, 0, 'h3FF, 0, 0, 0, 0};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni, run_en, ofs_req, act_n = 1'b1, resp_en = 1'b1;
  logic [15:0] period;
  logic signed [10:0] ofs_val;
  logic cstart_no, sel_no, rstb_no, wstb_no, dbus_oe, valid, ovr, done, err, overrun, tmo;
  logic [12:0] dbus_i, dbus_o, res = 13'h00F3, next_res = 13'h0A51;
  logic [11:0] data;

  adc_par_host #(.CNV_LOW(CNV_LOW), .RD_W(RD_W), .WR_W(WR_W), .QUIET(QUIET),
                 .BUSY_TMO(BUSY_TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .run_en_i(run_en), .period_i(period),
    .cstart_no(cstart_no), .conv_active_ni(act_n), .sel_no(sel_no), .rstb_no(rstb_no),
    .wstb_no(wstb_no), .dbus_i(dbus_i), .dbus_o(dbus_o), .dbus_oe_o(dbus_oe),
    .smp_valid_o(valid), .smp_data_o(data), .smp_ovr_o(ovr), .ofs_req_i(ofs_req),
    .ofs_val_i(ofs_val), .ofs_done_o(done), .ofs_err_o(err), .overrun_o(overrun),
    .conv_tmo_o(tmo));

  assign dbus_i = (!sel_no && !rstb_no) ? res : 13'h1555;

  int checks = 0, errors = 0, cyc = 0, conv_left = 0;
  int starts = 0, reads = 0, writes = 0, samples = 0, dones = 0, errs = 0, ovrs = 0, tmos = 0;
  int data_bad = 0, viol = 0, oe_bad = 0, overlap = 0, gap = 1000, gap_at_start = 1000;
  int low_cnt = 0, last_low_w = 0, rd_cnt = 0, last_rd_w = 0, wr_cnt = 0, last_wr_w = 0;
  int rd_rise_cyc = 0, vld_cyc = 0, fall_cyc = 0, tmo_cyc = 0, lim = 0;
  int s0 = 0, r0 = 0, w0 = 0, e0 = 0, o0 = 0, t0 = 0, d0 = 0;
  logic [12:0] last_word = '0;
  logic p_c = 1'b1, p_r = 1'b1, p_w = 1'b1;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Converter model and bus monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (!rstb_no || !wstb_no) gap = 0;
      else if (gap < 1000) gap++;
      if ((!cstart_no) + (!rstb_no) + (!wstb_no) > 1) overlap++;
      if (dbus_oe && wstb_no) oe_bad++;
      if (!rstb_no && !act_n) viol++;
      if (p_c && !cstart_no) begin
        starts++; low_cnt = 1; fall_cyc = cyc; gap_at_start = gap;
        if (resp_en) begin act_n <= 1'b0; conv_left = CONV_CYC; end
      end else if (!cstart_no) low_cnt++;
      if (!p_c && cstart_no) last_low_w = low_cnt;
      if (conv_left > 0) begin
        conv_left--;
        if (conv_left == 0) begin
          act_n <= 1'b1; res <= next_res; next_res <= next_res + 13'h0537;
        end
      end
      if (p_r && !rstb_no) begin reads++; rd_cnt = 1; end
      else if (!rstb_no) rd_cnt++;
      if (!p_r && rstb_no) begin last_rd_w = rd_cnt; rd_rise_cyc = cyc; end
      if (p_w && !wstb_no) begin writes++; wr_cnt = 1; last_word = dbus_o; end
      else if (!wstb_no) wr_cnt++;
      if (!p_w && wstb_no) last_wr_w = wr_cnt;
      if (valid) begin
        samples++; vld_cyc = cyc;
        if ({ovr, data} != res) data_bad++;
      end
      if (done) dones++;
      if (err) errs++;
      if (overrun) ovrs++;
      if (tmo) begin tmos++; tmo_cyc = cyc; end
      p_c = cstart_no; p_r = rstb_no; p_w = wstb_no;
    end
  end

  initial begin
    rst_ni = 1'b0; run_en = 1'b0; ofs_req = 1'b0; ofs_val = '0; period = 16'd40;
    repeat (3) step();
    // R1: idle outputs during reset
    chk(cstart_no && sel_no && rstb_no && wstb_no, "R1 strobes in reset",
        {cstart_no, sel_no, rstb_no, wstb_no}, 15);
    chk(!dbus_oe && !valid && !done && !err && !overrun && !tmo, "R1 flags in reset",
        {dbus_oe, valid, done, err, overrun, tmo}, 0);
    rst_ni = 1'b1;
    repeat (4) step();
    chk(cstart_no && sel_no && rstb_no && wstb_no && !dbus_oe, "R1 after release",
        {cstart_no, sel_no, rstb_no, wstb_no, dbus_oe}, 30);

    // Offset vectors: R6 formatting, R7 rejection
    for (int i = 0; i < NV; i++) begin
      w0 = writes; e0 = errs; d0 = dones;
      ofs_val = 11'(VEC_VAL[i]); ofs_req = 1'b1;
      step();
      ofs_req = 1'b0;
      repeat (12) step();
      if (VEC_ERR[i]) begin
        chk(errs == e0 + 1, "R7 error pulse", errs - e0, 1);
        chk(writes == w0, "R7 no write", writes - w0, 0);
      end else begin
        chk(writes == w0 + 1, "R6 one write", writes - w0, 1);
        chk(int'(last_word) == VEC_WRD[i], "R6 word", int'(last_word), VEC_WRD[i]);
        chk(last_wr_w == WR_W, "R6 strobe width", last_wr_w, WR_W);
        chk(dones == d0 + 1, "R6 done pulse", dones - d0, 1);
      end
    end
    chk(oe_bad == 0, "R11 bus released", oe_bad, 0);

    // R5: a start that falls due during a write waits for the quiet window
    s0 = starts;
    ofs_val = 11'sd64; ofs_req = 1'b1; period = 16'd3; run_en = 1'b1;
    step();
    ofs_req = 1'b0;
    lim = 0;
    while (starts == s0 && lim < 60) begin step(); lim++; end
    run_en = 1'b0;
    chk(starts == s0 + 1, "R5 start after write", starts - s0, 1);
    chk(gap_at_start >= QUIET, "R5 quiet window", gap_at_start, QUIET);
    repeat (40) step();

    // R2/R3/R4: steady sampling
    s0 = samples; o0 = ovrs; period = 16'd40; run_en = 1'b1;
    lim = 0;
    while (samples < s0 + 4 && lim < 400) begin step(); lim++; end
    run_en = 1'b0;
    chk(samples >= s0 + 4, "R4 samples produced", samples - s0, 4);
    chk(last_low_w == CNV_LOW, "R2 start pulse width", last_low_w, CNV_LOW);
    chk(last_rd_w == RD_W, "R4 read strobe width", last_rd_w, RD_W);
    chk(vld_cyc == rd_rise_cyc, "R4 valid timing", vld_cyc - rd_rise_cyc, 0);
    chk(data_bad == 0, "R4 sample data", data_bad, 0);
    chk(viol == 0, "R3 no read while active", viol, 0);
    chk(ovrs == o0, "R9 no overrun at long period", ovrs - o0, 0);
    repeat (40) step();

    // R8: write requested mid-conversion, latest request wins
    period = 16'd60; run_en = 1'b1;
    s0 = starts;
    lim = 0;
    while (starts == s0 && lim < 100) begin step(); lim++; end
    s0 = starts; r0 = reads; w0 = writes;
    step();
    ofs_val = 11'sd64; ofs_req = 1'b1; step();
    ofs_val = -11'sd1; step();
    ofs_req = 1'b0;
    lim = 0;
    while (writes == w0 && lim < 100) begin step(); lim++; end
    chk(reads == r0 + 1, "R8 read before write", reads - r0, 1);
    chk(starts == s0, "R8 write before next start", starts - s0, 0);
    chk(last_word == 13'h03FF, "R8 latest value", int'(last_word), 'h3FF);
    repeat (30) step();
    chk(writes == w0 + 1, "R8 single write", writes - w0, 1);
    run_en = 1'b0;
    repeat (60) step();

    // R9: period too short
    o0 = ovrs; s0 = samples; period = 16'd8; run_en = 1'b1;
    repeat (120) step();
    run_en = 1'b0;
    chk(ovrs > o0, "R9 overrun flagged", ovrs - o0, 1);
    chk(samples > s0, "R9 samples continue", samples - s0, 1);
    repeat (40) step();
    chk(overlap == 0, "R11 one strobe at a time", overlap, 0);

    // R10: converter never responds
    resp_en = 1'b0; t0 = tmos; r0 = reads; s0 = samples;
    period = 16'd200; run_en = 1'b1;
    lim = 0;
    while (tmos == t0 && lim < 300) begin step(); lim++; end
    run_en = 1'b0;
    chk(tmos == t0 + 1, "R10 timeout pulse", tmos - t0, 1);
    chk(tmo_cyc - fall_cyc == BUSY_TMO, "R10 timeout delay", tmo_cyc - fall_cyc, BUSY_TMO);
    chk(reads == r0 && samples == s0, "R10 no read", reads - r0, 0);
    resp_en = 1'b1;
    repeat (10) step();
    chk(viol == 0 && data_bad == 0, "R3 overall", viol + data_bad, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule